// File: doc/BRIEF.md
# Multi-Slave SPI Master with Run-Time Clock Mode

This block is a serial peripheral master that moves one byte in each direction per transfer. A byte goes out on the serial data output while a byte comes in on the serial data input. Each slave has its own active-low select line, and only one of them is driven low at a time. Software-level logic (or a sequencer) presents a transmit byte, a slave index, the clock polarity and phase bits and a half-period count, then strobes a start input. When the last serial clock edge has passed, the received byte is presented together with a single-cycle completion pulse.

The serial clock idles at the chosen polarity. Each half-period lasts a programmable number of system clocks. Bits leave most-significant first, and each incoming bit enters the low end of the same shift register. A hold request sampled at start keeps the select line low after the byte completes, so that a chain of slaves can receive a stream of bytes under one select pulse. The line is released at the end of a later byte that is started with the hold request clear.

Top module: `spi_master`

## Requirements
- R1: After reset all select lines are high, the completion pulse is low and the busy flag is low.
- R2: While no transfer is active and no select is held, the serial clock follows the polarity input within one system clock: it is low for polarity 0 and high for polarity 1.
- R3: From the clock edge that accepts a start until completion, exactly the select line numbered by the slave index is low and every other select line is high. At no time is more than one select line low.
- R4: The transmit byte appears on the serial output most-significant bit first, valid at every capture edge. The capture edge is the rising edge when polarity equals phase (modes 0 and 3) and the falling edge otherwise (modes 1 and 2). The serial output does not change on a capture edge.
- R5: The serial input is sampled on the capture edges. The eight samples, first sample as the most-significant bit, form the received byte, which is valid while the completion pulse is high.
- R6: With D equal to the half-period count (a count of 0 acts as 1), the completion pulse is high for exactly one system clock and rises 18*D clocks after the edge that accepted the start. The busy flag rises only at an edge that accepted a start.
- R7: With phase 0, the first (most-significant) transmit bit is on the serial output from the edge that accepts the start, before the first serial clock edge.
- R8: When the hold request is 1 at start, the addressed select line stays low after completion. When it is 0, all select lines are high from completion on.
- R9: A start strobe while busy is ignored. The running transfer keeps its select line, data and timing.
- R10: Each byte produces exactly 16 serial clock edges, and after completion the serial clock rests at the idle level of the polarity used for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start strobe, accepted when not busy |
| txByte | input | 8 | Byte to transmit |
| slaveIdx | input | 2 | Index of the slave to select |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| holdSel | input | 1 | Keep select low after this byte |
| halfDiv | input | 8 | Serial clock half-period in system clocks (0 acts as 1) |
| rxByte | output | 8 | Received byte |
| donePulse | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low select, one per slave |

## Verification
Select and busy change at the edge that accepts the start, and so does the first serial output bit when phase is 0. The bench samples them at the falling system clock edge right after the start is taken. From there it counts falling edges until the completion pulse appears and requires that count to equal 18*D. It compares the received byte, the slave model's capture of the serial output, the edge count and the resting clock level at that same falling edge. One falling edge later it confirms that the pulse has dropped and that the select lines are released or held as the hold request asked.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } spimState_t;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;     // take the transmit byte
    logic capture;  // sample serial input into the bit latch
    logic shift;    // move the register one place, latch enters at lsb
    logic finish;   // publish the received byte
    logic phaMode;  // phase of the running byte
  } spimStrobe_t;

endpackage

// File: rtl/spim_seldec.sv
module spim_seldec #(
  parameter int NUM_SLAVES = 4,
  parameter int SEL_W      = 2
) (
  input  logic                  selActive,
  input  logic [SEL_W-1:0]      selIdx,
  output logic [NUM_SLAVES-1:0] csN
);

  for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_sel
    assign csN[i] = !(selActive && (selIdx == SEL_W'(i)));
  end

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [SEL_W-1:0] slaveIdx,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             holdSel,
  input  logic [DIV_W-1:0] halfDiv,
  output spimStrobe_t      strb,
  output logic             sclk,
  output logic             selActive,
  output logic [SEL_W-1:0] selIdx,
  output logic             busy,
  output logic             donePulse,
  output logic             cpolMode,
  output logic             cphaMode
);

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);

  spimState_t        state;
  logic [DIV_W-1:0]  halfCnt;
  logic [DIV_W-1:0]  divL;
  logic [DIV_W-1:0]  divLast;
  logic [EDGE_W-1:0] edgeCnt;
  logic              holdL;
  logic              sclkR;
  logic              tick;
  logic              leadEdge;
  logic              edgeTick;

  assign divLast  = (divL == '0) ? '0 : divL - 1'b1;
  assign tick     = (halfCnt == divLast);
  assign leadEdge = ~edgeCnt[0];
  assign edgeTick = (state == ST_SHIFT) && tick;

  always_comb begin
    strb.load    = (state == ST_IDLE) && startReq;
    strb.capture = edgeTick && (cphaMode ? !leadEdge : leadEdge);
    strb.shift   = edgeTick && (cphaMode ? (leadEdge && edgeCnt != '0) : !leadEdge);
    strb.finish  = (state == ST_TAIL) && tick;
    strb.phaMode = cphaMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      divL      <= '0;
      edgeCnt   <= '0;
      holdL     <= 1'b0;
      sclkR     <= 1'b0;
      selActive <= 1'b0;
      selIdx    <= '0;
      cpolMode  <= 1'b0;
      cphaMode  <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!selActive) sclkR <= cpol;
          if (startReq) begin
            state     <= ST_SETUP;
            halfCnt   <= '0;
            edgeCnt   <= '0;
            divL      <= halfDiv;
            holdL     <= holdSel;
            cpolMode  <= cpol;
            cphaMode  <= cpha;
            sclkR     <= cpol;
            selActive <= 1'b1;
            selIdx    <= slaveIdx;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            halfCnt <= '0;
            state   <= ST_SHIFT;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            halfCnt <= '0;
            sclkR   <= ~sclkR;
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == EDGE_W'(EDGES - 1)) state <= ST_TAIL;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            halfCnt   <= '0;
            state     <= ST_IDLE;
            donePulse <= 1'b1;
            selActive <= holdL;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclkR;
  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spim_dpath.sv
module spim_dpath
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strb,
  input  logic [DATA_W-1:0] txByte,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxByte
);

  logic [DATA_W-1:0] shReg;
  logic              bitL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitL   <= 1'b0;
      rxByte <= '0;
    end else begin
      if (strb.load) shReg <= txByte;
      if (strb.capture) bitL <= miso;
      if (strb.shift) shReg <= {shReg[DATA_W-2:0], bitL};
      if (strb.finish) rxByte <= strb.phaMode ? {shReg[DATA_W-2:0], bitL} : shReg;
    end
  end

  assign mosi = shReg[DATA_W-1];

endmodule

// File: rtl/spi_master.sv
module spi_master
  import spim_pkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  localparam int SEL_W     = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic [DATA_W-1:0]     txByte,
  input  logic [SEL_W-1:0]      slaveIdx,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic                  holdSel,
  input  logic [DIV_W-1:0]      halfDiv,
  output logic [DATA_W-1:0]     rxByte,
  output logic                  donePulse,
  output logic                  busy,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso,
  output logic [NUM_SLAVES-1:0] csN
);

  spimStrobe_t      strb;
  logic             selActive;
  logic [SEL_W-1:0] selIdx;
  logic             cpolMode;
  logic             cphaMode;

  spim_ctrl #(
    .NUM_SLAVES(NUM_SLAVES), .DATA_W(DATA_W), .DIV_W(DIV_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .slaveIdx(slaveIdx),
    .cpol(cpol), .cpha(cpha), .holdSel(holdSel), .halfDiv(halfDiv),
    .strb(strb), .sclk(sclk), .selActive(selActive), .selIdx(selIdx),
    .busy(busy), .donePulse(donePulse), .cpolMode(cpolMode), .cphaMode(cphaMode)
  );

  spim_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .txByte(txByte), .miso(miso),
    .mosi(mosi), .rxByte(rxByte)
  );

  spim_seldec #(.NUM_SLAVES(NUM_SLAVES), .SEL_W(SEL_W)) u_sel (
    .selActive(selActive), .selIdx(selIdx), .csN(csN)
  );

endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int NUM_SLAVES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startReq,
  input logic                  busy,
  input logic                  donePulse,
  input logic [NUM_SLAVES-1:0] csN,
  input logic                  sclk,
  input logic                  mosi,
  input logic                  cpolMode,
  input logic                  cphaMode
);

  // R3
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  // R9
  sel_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csN));

  // R4
  mosi_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (($rose(sclk) && (cpolMode == cphaMode)) ||
              ($fell(sclk) && (cpolMode != cphaMode)))) |-> $stable(mosi));

endmodule

bind spi_master spim_chk #(.NUM_SLAVES(NUM_SLAVES)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy),
  .donePulse(donePulse), .csN(csN), .sclk(sclk), .mosi(mosi),
  .cpolMode(cpolMode), .cphaMode(cphaMode)
);

// File: tb/spi_master_tb.sv
`timescale 1ns/1ps
module spi_master_tb;

  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [7:0]    txByte = '0;
  logic [1:0]    slaveIdx = '0;
  logic          cpol = 1'b0;
  logic          cpha = 1'b0;
  logic          holdSel = 1'b0;
  logic [7:0]    halfDiv = 8'd1;
  logic [7:0]    rxByte;
  logic          donePulse;
  logic          busy;
  logic          sclk;
  logic          mosi;
  logic          miso = 1'b0;
  logic [NS-1:0] csN;

  int vecCnt = 0;
  int errCnt = 0;

  // slave model state
  int         armSeq = 0;
  int         seenSeq = 0;
  int         slvEdges = 0;
  logic [7:0] slvRx = '0;
  logic [7:0] slvOut = '0;
  logic [7:0] slvTxT = '0;
  logic       cpolT = 1'b0;
  logic       cphaT = 1'b0;
  int         idxT = 0;

  always #2 clk = ~clk;

  spi_master u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .txByte(txByte),
    .slaveIdx(slaveIdx), .cpol(cpol), .cpha(cpha), .holdSel(holdSel),
    .halfDiv(halfDiv), .rxByte(rxByte), .donePulse(donePulse), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  // behavioural slave: capture on the mode's capture edge, launch on the other
  always @(sclk or armSeq) begin
    if (armSeq != seenSeq) begin
      seenSeq  = armSeq;
      slvEdges = 0;
      slvRx    = '0;
      if (!cphaT) begin
        miso   = slvTxT[7];
        slvOut = {slvTxT[6:0], 1'b0};
      end else begin
        miso   = 1'b0;
        slvOut = slvTxT;
      end
    end else if (rstN && csN[idxT] == 1'b0) begin
      slvEdges++;
      if ((sclk == 1'b1) == (cpolT == cphaT)) begin
        slvRx = {slvRx[6:0], mosi};
      end else begin
        miso   = slvOut[7];
        slvOut = {slvOut[6:0], 1'b0};
      end
    end
  end

  function automatic logic [NS-1:0] selMask(input int idx);
    logic [NS-1:0] m;
    m = '1;
    m[idx] = 1'b0;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] stx, input int idx,
                      input bit pol, input bit pha, input bit hold,
                      input int div, input bit interfere);
    int n;
    int dEff;
    int limit;
    bit csBad;
    logic [NS-1:0] expSel;
    dEff   = (div == 0) ? 1 : div;
    limit  = 18 * dEff + 40;
    expSel = selMask(idx);
    csBad  = 1'b0;
    @(negedge clk);
    cpol = pol; cpha = pha; halfDiv = 8'(div); slaveIdx = 2'(idx);
    txByte = tx; holdSel = hold;
    cpolT = pol; cphaT = pha; idxT = idx; slvTxT = stx;
    armSeq++;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    n = 0;
    check(csN == expSel, "R3", "select at start", int'(csN), int'(expSel));
    check(busy == 1'b1, "R6", "busy after start", int'(busy), 1);
    if (!pha) check(mosi == tx[7], "R7", "first bit before first edge", int'(mosi), int'(tx[7]));
    while (!donePulse && n < limit) begin
      @(negedge clk);
      n++;
      if (interfere && n == 3) begin
        startReq = 1'b1;
        txByte   = ~tx;
        slaveIdx = 2'((idx + 1) % NS);
      end
      if (interfere && n == 4) startReq = 1'b0;
      if (!donePulse && csN != expSel) csBad = 1'b1;
    end
    check(n == 18 * dEff, "R6", "cycles to done", n, 18 * dEff);
    check(rxByte == stx, "R5", "received byte", int'(rxByte), int'(stx));
    check(slvRx == tx, "R4", "slave captured byte", int'(slvRx), int'(tx));
    check(slvEdges == 16, "R10", "serial clock edges", slvEdges, 16);
    check(sclk == pol, "R10", "rest level after byte", int'(sclk), int'(pol));
    check(!csBad, interfere ? "R9" : "R3", "select steady during byte", int'(csBad), 0);
    @(negedge clk);
    check(donePulse == 1'b0, "R6", "done width", int'(donePulse), 0);
    check(csN == (hold ? expSel : {NS{1'b1}}), "R8", "select after done",
          int'(csN), int'(hold ? expSel : {NS{1'b1}}));
  endtask

  initial begin
    #(4 * 150000);
    errCnt++;
    $display("FAIL R6 watchdog actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(csN == {NS{1'b1}}, "R1", "select in reset", int'(csN), int'({NS{1'b1}}));
    check(donePulse == 1'b0, "R1", "done in reset", int'(donePulse), 0);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(csN == {NS{1'b1}}, "R1", "select after reset", int'(csN), int'({NS{1'b1}}));

    cpol = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk == 1'b1, "R2", "idle clock pol1", int'(sclk), 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk == 1'b0, "R2", "idle clock pol0", int'(sclk), 0);

    // directed: every mode, extreme patterns, divider corners
    xfer(8'hA5, 8'h3C, 0, 1'b0, 1'b0, 1'b0, 1, 1'b0);
    xfer(8'h4F, 8'hD2, 1, 1'b0, 1'b1, 1'b0, 2, 1'b0);
    xfer(8'h80, 8'h01, 2, 1'b1, 1'b0, 1'b0, 3, 1'b0);
    xfer(8'hFF, 8'h00, 3, 1'b1, 1'b1, 1'b0, 1, 1'b0);
    xfer(8'h00, 8'hFF, 1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    xfer(8'h4B, 8'h96, 3, 1'b1, 1'b1, 1'b0, 5, 1'b0);
    // R9: start while busy
    xfer(8'h5A, 8'hC3, 2, 1'b0, 1'b1, 1'b0, 2, 1'b1);
    xfer(8'h17, 8'h71, 0, 1'b1, 1'b0, 1'b0, 1, 1'b1);
    // R8: held select across a three-byte stream
    xfer(8'h11, 8'h22, 2, 1'b0, 1'b0, 1'b1, 2, 1'b0);
    repeat (5) @(negedge clk);
    check(csN == selMask(2), "R8", "select held while idle", int'(csN), int'(selMask(2)));
    xfer(8'h33, 8'h44, 2, 1'b0, 1'b0, 1'b1, 2, 1'b0);
    xfer(8'h55, 8'h66, 2, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    repeat (3) @(negedge clk);
    check(csN == {NS{1'b1}}, "R8", "select released", int'(csN), int'({NS{1'b1}}));

    // constrained random
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a;
      logic [7:0] b;
      int ix;
      int dv;
      a  = 8'($urandom);
      b  = 8'($urandom);
      ix = int'($urandom % NS);
      dv = int'($urandom % 5);
      xfer(a, b, ix, 1'($urandom), 1'($urandom), 1'b0, dv, 1'($urandom % 6 == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule